// File: doc/BRIEF.md
# Universal Bus Transceiver Register

This block moves data in two independent directions between an A side and a B side. Each direction has its own storage element and its own controls. While a path's latch enable is high, the stored value tracks the source bus and the destination sees the source directly. While the latch enable is low, the path holds its value. It takes a new value only on a qualified rising edge of its own path clock. A path clock edge is qualified when the path's active-low clock enable is low.

The bus pins are split into separate input, data-output and output-enable vectors, so synthesis never has to handle an inout. A pad wrapper can combine each side's output and enable into tri-state pins. Each direction has an active-low output enable. After reset, an enable level that was already asserted is not honoured. A direction starts driving only after its enable has been seen released at a system clock edge and then asserted again. The path clocks are sampled on the system clock `clk`, so a path clock edge is detected as a low-to-high change between two consecutive `clk` samples.

Top module: `ubt_core`

## Requirements
- R1: The two directions are independent. No control or data input of one direction changes the other direction's data output or output-enable vector.
- R2: While a direction's latch enable is 1, its data output equals its source input bit for bit, without inversion, in the same cycle. The stored value is loaded from the source at every `clk` edge.
- R3: While the latch enable is 0 and there is no qualified path clock edge, the stored value and the data output stay unchanged across `clk` edges, including while the path clock is held at 1.
- R4: While the latch enable is 0, a path clock sample of 1 following a sample of 0, with the clock enable at 0, loads the source value at that `clk` edge.
- R5: A path clock rise with the active-low clock enable at 1 loads nothing.
- R6: The output-enable vector is all ones when the direction drives and all zeros otherwise. Driving requires the active-low enable to be 0.
- R7: The synchronous active-high reset `rst` clears both stored values to zero and turns off both output-enable vectors from the following cycle.
- R8: After reset, a direction drives only once its enable has been sampled at 1 at a `clk` edge outside reset. An enable held at 0 through and after reset keeps the outputs off.
- R9: When the latch enable falls, the path keeps the source value sampled at the last `clk` edge at which the latch enable was 1.
- R10: Both directions may drive at the same time. The block does not arbitrate between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Data sampled from the A side |
| b_in | input | W | Data sampled from the B side |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable |
| ab_cp | input | 1 | A-to-B path clock, sampled on clk |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_cp | input | 1 | B-to-A path clock, sampled on clk |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| b_out | output | W | Data presented to the B side |
| b_oe | output | W | Per-bit drive enable for the B side |
| a_out | output | W | Data presented to the A side |
| a_oe | output | W | Per-bit drive enable for the A side |

## Verification
Two things can land in the same cycle: the latch enable falling while the path clock rises, and both directions driving at once. The first is provoked by dropping the latch enable with the source changing on the following edge; the result is judged against the value sampled at the last transparent edge. The second is provoked by enabling both directions together; it is reported as a bus conflict and judged only by both enable vectors being all ones. A free-running model in the bench compares all four outputs on every clock while pseudo-random controls, path clocks and a mid-run reset exercise every pairing of hold, capture and transparency.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    localparam int UBT_DIRS = 2;
    localparam int DIR_AB   = 0;
    localparam int DIR_BA   = 1;

    typedef struct packed {
        logic oe_n;
        logic le;
        logic cp;
        logic ce_n;
    } ubt_ctrl_t;

    typedef enum logic [1:0] {
        UBT_PASS = 2'd0,
        UBT_HOLD = 2'd1,
        UBT_GRAB = 2'd2
    } ubt_mode_e;

    // Transparency wins over the clocked path; a gated edge is a hold.
    function automatic ubt_mode_e ubt_mode(input logic le, input logic rise,
                                           input logic ce_n);
        if (le)
            return UBT_PASS;
        else if (rise && !ce_n)
            return UBT_GRAB;
        else
            return UBT_HOLD;
    endfunction

endpackage

// File: rtl/ubt_store.sv
module ubt_store
    import ubt_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src,
    input  ubt_ctrl_t    ctrl,
    output logic [W-1:0] dout
);
    logic [W-1:0] held;
    logic         cp_q;
    ubt_mode_e    mode;

    assign mode = ubt_mode(ctrl.le, ctrl.cp & ~cp_q, ctrl.ce_n);

    always_ff @(posedge clk) begin
        cp_q <= ctrl.cp;
        if (rst)
            held <= '0;
        else if (mode != UBT_HOLD)
            held <= src;
    end

    // Transparent path bypasses the register so the output follows at once.
    assign dout = ctrl.le ? src : held;
endmodule

// File: rtl/ubt_drive.sv
module ubt_drive #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         oe_n,
    output logic [W-1:0] oe
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (oe_n)
            armed <= 1'b1;
    end

    assign oe = {W{armed & ~oe_n}};
endmodule

// File: rtl/ubt_core.sv
module ubt_core
    import ubt_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_cp,
    input  logic         ab_ce_n,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_cp,
    input  logic         ba_ce_n,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe
);
    logic [W-1:0] src_v [UBT_DIRS];
    logic [W-1:0] dat_v [UBT_DIRS];
    logic [W-1:0] oe_v  [UBT_DIRS];
    ubt_ctrl_t    ctl_v [UBT_DIRS];

    assign src_v[DIR_AB] = a_in;
    assign src_v[DIR_BA] = b_in;
    assign ctl_v[DIR_AB] = '{oe_n: ab_oe_n, le: ab_le, cp: ab_cp, ce_n: ab_ce_n};
    assign ctl_v[DIR_BA] = '{oe_n: ba_oe_n, le: ba_le, cp: ba_cp, ce_n: ba_ce_n};

    for (genvar d = 0; d < UBT_DIRS; d++) begin : g_dir
        ubt_store #(.W(W)) store_i (
            .clk  (clk),
            .rst  (rst),
            .src  (src_v[d]),
            .ctrl (ctl_v[d]),
            .dout (dat_v[d])
        );
        ubt_drive #(.W(W)) drive_i (
            .clk  (clk),
            .rst  (rst),
            .oe_n (ctl_v[d].oe_n),
            .oe   (oe_v[d])
        );
    end

    assign b_out = dat_v[DIR_AB];
    assign b_oe  = oe_v[DIR_AB];
    assign a_out = dat_v[DIR_BA];
    assign a_oe  = oe_v[DIR_BA];
endmodule

// File: rtl/ubt_chk.sv
module ubt_chk #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         ab_oe_n,
    input logic         ab_le,
    input logic         ab_cp,
    input logic         ab_ce_n,
    input logic         ba_oe_n,
    input logic         ba_le,
    input logic         ba_cp,
    input logic         ba_ce_n,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_oe,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_oe
);
    a_r2_ab_transparent: assert property (@(posedge clk) disable iff (rst)
        ab_le |-> b_out == a_in);
    a_r2_ba_transparent: assert property (@(posedge clk) disable iff (rst)
        ba_le |-> a_out == b_in);

    a_r3_ab_hold: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && !(ab_cp && !$past(ab_cp))) |=> (ab_le || $stable(b_out)));
    a_r3_ba_hold: assert property (@(posedge clk) disable iff (rst)
        (!ba_le && !(ba_cp && !$past(ba_cp))) |=> (ba_le || $stable(a_out)));

    a_r4_ab_capture: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && ab_cp && !$past(ab_cp) && !ab_ce_n) |=> (ab_le || b_out == $past(a_in)));
    a_r4_ba_capture: assert property (@(posedge clk) disable iff (rst)
        (!ba_le && ba_cp && !$past(ba_cp) && !ba_ce_n) |=> (ba_le || a_out == $past(b_in)));

    a_r5_ab_gated: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && ab_ce_n) |=> (ab_le || $stable(b_out)));

    a_r6_b_oe_shape: assert property (@(posedge clk)
        (b_oe == '0) || (b_oe == '1 && !ab_oe_n));
    a_r6_a_oe_shape: assert property (@(posedge clk)
        (a_oe == '0) || (a_oe == '1 && !ba_oe_n));

    a_r7_reset_off: assert property (@(posedge clk)
        rst |=> (b_oe == '0 && a_oe == '0));
    a_r7_reset_clear: assert property (@(posedge clk)
        rst |=> (ab_le || b_out == '0));
endmodule

bind ubt_core ubt_chk #(.W(W)) chk_i (.*);

// File: tb/ubt_core_tb_top.sv
`timescale 1ns/1ps
module ubt_core_tb_top;
    localparam int W = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic ab_oe_n = 1'b0, ab_le = 1'b0, ab_cp = 1'b0, ab_ce_n = 1'b0;
    logic ba_oe_n = 1'b0, ba_le = 1'b0, ba_cp = 1'b0, ba_ce_n = 1'b0;
    logic [W-1:0] b_out, b_oe, a_out, a_oe;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ubt_core #(.W(W)) dut_i (.*);

    // Behavioural reference: index 0 is A-to-B, 1 is B-to-A.
    logic [W-1:0] m_st [2] = '{default: '0};
    bit           m_pv [2] = '{default: 0};
    bit           m_arm[2] = '{default: 0};

    task automatic chk(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
        end
    endtask

    task automatic upd(input int d, input logic [W-1:0] src, input bit le,
                       input bit cp, input bit ce_n, input bit oe_n);
        if (rst) begin
            m_st[d] = '0;
            m_arm[d] = 0;
        end else begin
            if (le) m_st[d] = src;
            else if (cp && !m_pv[d] && !ce_n) m_st[d] = src;
            if (oe_n) m_arm[d] = 1;
        end
        m_pv[d] = cp;
    endtask

    always @(posedge clk) begin
        logic [W-1:0] eb, ea, eboe, eaoe;
        upd(0, a_in, ab_le, ab_cp, ab_ce_n, ab_oe_n);
        upd(1, b_in, ba_le, ba_cp, ba_ce_n, ba_oe_n);
        #1;
        if (!done) begin
            eb   = ab_le ? a_in : m_st[0];
            ea   = ba_le ? b_in : m_st[1];
            eboe = (m_arm[0] && !ab_oe_n) ? '1 : '0;
            eaoe = (m_arm[1] && !ba_oe_n) ? '1 : '0;
            chk(b_out == eb, ab_le ? "R2 model b_out" : "R3 model b_out", b_out, eb);
            chk(a_out == ea, ba_le ? "R2 model a_out" : "R3 model a_out", a_out, ea);
            chk(b_oe == eboe, "R6 model b_oe", b_oe, eboe);
            chk(a_oe == eaoe, "R6 model a_oe", a_oe, eaoe);
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        logic [W-1:0] keep;
        // Reset with enables already asserted
        tick(); tick();
        chk(b_oe == '0 && a_oe == '0, "R7 enables off in reset", b_oe, '0);
        chk(b_out == '0, "R7 stored cleared", b_out, '0);
        rst = 1'b0;
        tick();
        chk(b_oe == '0, "R8 held-low enable ignored", b_oe, '0);
        ab_oe_n = 1'b1; ba_oe_n = 1'b1;
        tick();
        ab_oe_n = 1'b0; ba_oe_n = 1'b0;
        #1;
        chk(b_oe == '1, "R8 b side drives after release", b_oe, '1);
        chk(a_oe == '1, "R10 both directions drive", a_oe, '1);
        if (a_oe == '1 && b_oe == '1) $display("NOTE bus conflict: both directions driving");

        // Transparency
        ab_le = 1'b1; a_in = 18'h2AAAA;
        tick();
        chk(b_out == 18'h2AAAA, "R2 transparent", b_out, 18'h2AAAA);
        a_in = 18'h01234;
        #1;
        chk(b_out == 18'h01234, "R2 follows mid-cycle", b_out, 18'h01234);
        a_in = 18'h12345;
        tick();
        // Latch enable falls, source changes
        ab_le = 1'b0; a_in = 18'h3FFFF;
        tick();
        chk(b_out == 18'h12345, "R9 value at le fall", b_out, 18'h12345);
        tick(); tick();
        chk(b_out == 18'h12345, "R3 hold no edge", b_out, 18'h12345);
        // Capture
        ab_cp = 1'b1;
        tick();
        chk(b_out == 18'h3FFFF, "R4 capture on rise", b_out, 18'h3FFFF);
        a_in = 18'h00111;
        tick();
        chk(b_out == 18'h3FFFF, "R3 hold with clock high", b_out, 18'h3FFFF);
        ab_cp = 1'b0; ab_ce_n = 1'b1; a_in = 18'h00F0F;
        tick();
        ab_cp = 1'b1;
        tick();
        chk(b_out == 18'h3FFFF, "R5 gated rise ignored", b_out, 18'h3FFFF);
        ab_cp = 1'b0; ab_ce_n = 1'b0;

        // B-to-A independent of A-to-B
        keep = b_out;
        ba_le = 1'b1; b_in = 18'h15555; ba_cp = 1'b1; ba_ce_n = 1'b1;
        tick();
        chk(a_out == 18'h15555, "R1 B-to-A path", a_out, 18'h15555);
        chk(b_out == keep, "R1 A-to-B untouched", b_out, keep);
        ba_le = 1'b0; ba_cp = 1'b0; ba_ce_n = 1'b0; b_in = 18'h0ABCD;
        tick();
        ba_cp = 1'b1;
        tick();
        chk(a_out == 18'h0ABCD, "R4 B-to-A capture", a_out, 18'h0ABCD);
        ab_oe_n = 1'b1;
        #1;
        chk(b_oe == '0, "R6 disable tri-states b", b_oe, '0);
        chk(a_oe == '1, "R1 a side still drives", a_oe, '1);

        // Pseudo-random phase with a mid-run reset
        lf = 32'hACE1_2468;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            a_in = lf[W-1:0];
            b_in = lf[31:32-W];
            ab_le = lf[3] & lf[7]; ba_le = lf[4] & lf[9];
            ab_cp = lf[5]; ba_cp = lf[11];
            ab_ce_n = lf[13] & lf[2]; ba_ce_n = lf[17] & lf[6];
            ab_oe_n = lf[19] & lf[8]; ba_oe_n = lf[23] & lf[10];
            rst = (i >= 300 && i < 303);
            tick();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule